// File: doc/BRIEF.md
# Shift-Add Multiply-Accumulate Engine

The engine evaluates 1 + x + y + z·t for unsigned operands that arrive on one narrow input bus. It returns the value in a result register twice the width of the bus. The datapath has one adder with a carry-in, one result accumulator, a multiplier register that shifts right and a multiplicand register that shifts left. The pre-sum and the product share the adder and the accumulator. The constant one enters through the adder's carry-in while x is added. A zero detect on the multiplier register ends the shift-and-add loop as soon as no set bits are left.

A one-cycle `start_i` pulse in idle clears all three registers. The engine then takes four operand beats, each marked by `beat_valid_i`, in the order t, z, x, y. Cycles with the strobe low are waited out. The multiplier and multiplicand are therefore loaded before any arithmetic takes place. When the loop has finished, `done_o` pulses for one cycle and `result_o` holds the final value until the next start.

Top module: `shift_mac_engine`

## Requirements
- R1: After a synchronous reset, result_o is 0 and done_o and busy_o are both 0.
- R2: A start_i pulse in idle clears the result, multiplier and multiplicand registers at that clock edge and raises busy_o; result_o reads 0 in the following cycle.
- R3: The beats are taken in the order t, z, x, y, one per cycle in which beat_valid_i is high. Cycles with beat_valid_i low are ignored and the engine waits in the same load step.
- R4: The x beat loads the result register with x + 1, the one coming through the adder carry-in. The y beat then makes the result 1 + x + y.
- R5: When done_o is high, result_o equals (1 + x + y + z·t) mod 2^16, with the 8-bit operands zero-extended.
- R6: An add iteration takes two cycles: first the add using the unshifted multiplicand, then the shift. A skip iteration takes one cycle. done_o is high in cycle b + p + 2 after the y beat's edge, where b is the bit length of t and p its number of set bits.
- R7: A multiplier of zero skips the loop: done_o is high in the second cycle after the y beat and result_o is 1 + x + y.
- R8: done_o is high for exactly one cycle. busy_o falls in the cycle after it, and result_o holds its value while idle.
- R9: A start_i pulse while busy_o is high has no effect on the operation in progress, on its result or on its timing.
- R10: A reset during an operation returns the engine to idle with all registers cleared, and a following start runs normally.
- R11: In every shift cycle the multiplier register shifts right by one and the multiplicand register shifts left by one in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start request, taken only in idle |
| beat_valid_i | input | 1 | Marks a valid operand beat on beat_data_i |
| beat_data_i | input | 8 | Operand bus, unsigned |
| busy_o | output | 1 | High from start until the done cycle inclusive |
| done_o | output | 1 | One-cycle pulse when result_o is final |
| result_o | output | 16 | Accumulator contents |

## Verification
The bench builds the engine with the default 8-bit operand width and 16-bit accumulator. At these widths every t value has a bit length of at most eight, so the exact done cycle (b + p + 2) can be predicted for sparse, dense and single-bit multipliers. The all-ones operand set sums to exactly 2^16, which makes the wrap to zero reachable. The cases with beat gaps, a start during a run and a reset mid-run exercise the controller's waiting and ignoring paths at these same widths.

// File: rtl/smac_pkg.sv
package smac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LD_T  = 3'd1,
    ST_LD_Z  = 3'd2,
    ST_ADD_X = 3'd3,
    ST_ADD_Y = 3'd4,
    ST_LOOP  = 3'd5,
    ST_SHIFT = 3'd6,
    ST_DONE  = 3'd7
  } smac_state_e;

endpackage

// File: rtl/smac_shreg.sv
module smac_shreg #(
  parameter int W          = 16,
  parameter bit SHIFT_LEFT = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic [W-1:0] q
);

  logic [W-1:0] shifted;

  generate
    if (SHIFT_LEFT) begin : g_left
      assign shifted = {q[W-2:0], 1'b0};
    end else begin : g_right
      assign shifted = {1'b0, q[W-1:1]};
    end
  endgenerate

  // reset and clear win over load, and load wins over shift
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (load) begin
      q <= load_val;
    end else if (shift) begin
      q <= shifted;
    end
  end

endmodule

// File: rtl/smac_accum.sv
module smac_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] addend,
  input  logic         cin,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] add_wrap(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic         c);
    return a + b + {{(W-1){1'b0}}, c};
  endfunction

  logic [W-1:0] sum;
  assign sum = add_wrap(q, addend, cin);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (load) begin
      q <= sum;
    end
  end

  AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0)); // R2

endmodule

// File: rtl/smac_zero.sv
module smac_zero #(
  parameter int W = 16
) (
  input  logic [W-1:0] vec,
  output logic         is_zero,
  output logic         lsb
);

  assign is_zero = ~(|vec);
  assign lsb     = vec[0];

endmodule

// File: rtl/smac_ctrl.sv
module smac_ctrl
  import smac_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic beat_valid,
  input  logic t_zero,
  input  logic t_lsb,
  output logic clr,
  output logic ld_t,
  output logic ld_z,
  output logic acc_ld,
  output logic sel_bus,
  output logic cin,
  output logic shift,
  output logic busy,
  output logic done
);

  smac_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    clr      = 1'b0;
    ld_t     = 1'b0;
    ld_z     = 1'b0;
    acc_ld   = 1'b0;
    sel_bus  = 1'b0;
    cin      = 1'b0;
    shift    = 1'b0;
    done     = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        clr      = 1'b1;
        state_nx = ST_LD_T;
      end
      ST_LD_T: if (beat_valid) begin
        ld_t     = 1'b1;
        state_nx = ST_LD_Z;
      end
      ST_LD_Z: if (beat_valid) begin
        ld_z     = 1'b1;
        state_nx = ST_ADD_X;
      end
      ST_ADD_X: if (beat_valid) begin
        acc_ld   = 1'b1;
        sel_bus  = 1'b1;
        cin      = 1'b1;
        state_nx = ST_ADD_Y;
      end
      ST_ADD_Y: if (beat_valid) begin
        acc_ld   = 1'b1;
        sel_bus  = 1'b1;
        state_nx = ST_LOOP;
      end
      ST_LOOP: begin
        if (t_zero) begin
          state_nx = ST_DONE;
        end else if (t_lsb) begin
          acc_ld   = 1'b1;
          state_nx = ST_SHIFT;
        end else begin
          shift    = 1'b1;
        end
      end
      ST_SHIFT: begin
        shift    = 1'b1;
        state_nx = ST_LOOP;
      end
      ST_DONE: begin
        done     = 1'b1;
        state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_LOOP_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOOP && t_zero) |=> done); // R6
  AST_START_IDLE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (busy && start && state != ST_DONE) |=> busy); // R9

endmodule

// File: rtl/shift_mac_engine.sv
module shift_mac_engine #(
  parameter int IN_W  = 8,
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             beat_valid_i,
  input  logic [IN_W-1:0]  beat_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [ACC_W-1:0] result_o
);

  function automatic logic [ACC_W-1:0] widen(input logic [IN_W-1:0] d);
    return {{(ACC_W-IN_W){1'b0}}, d};
  endfunction

  logic             clr, ld_t, ld_z, acc_ld, sel_bus, cin, shift;
  logic             t_zero, t_lsb;
  logic [ACC_W-1:0] bus_wide, t_q, z_q, res_q, addend;

  assign bus_wide = widen(beat_data_i);
  assign addend   = sel_bus ? bus_wide : z_q;

  smac_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start      (start_i),
    .beat_valid (beat_valid_i),
    .t_zero     (t_zero),
    .t_lsb      (t_lsb),
    .clr        (clr),
    .ld_t       (ld_t),
    .ld_z       (ld_z),
    .acc_ld     (acc_ld),
    .sel_bus    (sel_bus),
    .cin        (cin),
    .shift      (shift),
    .busy       (busy_o),
    .done       (done_o)
  );

  smac_shreg #(.W(ACC_W), .SHIFT_LEFT(1'b0)) u_mplier (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load     (ld_t),
    .load_val (bus_wide),
    .shift    (shift),
    .q        (t_q)
  );

  smac_shreg #(.W(ACC_W), .SHIFT_LEFT(1'b1)) u_mcand (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .load     (ld_z),
    .load_val (bus_wide),
    .shift    (shift),
    .q        (z_q)
  );

  smac_zero #(.W(ACC_W)) u_zchk (
    .vec     (t_q),
    .is_zero (t_zero),
    .lsb     (t_lsb)
  );

  smac_accum #(.W(ACC_W)) u_acc (
    .clk    (clk),
    .rst    (rst),
    .clr    (clr),
    .load   (acc_ld),
    .addend (addend),
    .cin    (cin),
    .q      (res_q)
  );

  assign result_o = res_q;

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
    clr |=> (t_q == '0 && z_q == '0 && res_q == '0)); // R2
  AST_SHIFT_PAIR: assert property (@(posedge clk) disable iff (rst)
    shift |=> (t_q == ($past(t_q) >> 1) && z_q == ($past(z_q) << 1))); // R11
  AST_MUL_ADD: assert property (@(posedge clk) disable iff (rst)
    (acc_ld && !sel_bus) |=> (res_q == $past(res_q) + $past(z_q))); // R5
  AST_ADD_BEFORE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (acc_ld && !sel_bus) |-> !shift); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i) |=> $stable(res_q)); // R8

endmodule

// File: tb/shift_mac_engine_bench.sv
module shift_mac_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic        beat_valid_i = 1'b0;
  logic [7:0]  beat_data_i = '0;
  logic        busy_o, done_o;
  logic [15:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  shift_mac_engine u_shift_mac_engine (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .beat_valid_i (beat_valid_i),
    .beat_data_i  (beat_data_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input logic [7:0] d, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    beat_valid_i = 1'b1;
    beat_data_i  = d;
    @(negedge clk);
    beat_valid_i = 1'b0;
    beat_data_i  = 8'hxx;
  endtask

  // full operation; poke puts a start pulse in the loop phase (R9)
  task automatic run_case(input logic [7:0] x, y, z, t, input int gap, input bit poke);
    int b = 0, p = 0, cnt;
    int expv;
    for (int i = 0; i < 8; i++) if (t[i]) begin b = i + 1; p++; end
    expv = (1 + x + y + z * t) % 65536;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 clear", result_o, 0);
    chk("R2 busy", busy_o, 1);
    beat(t, gap);
    beat(z, gap);
    beat(x, gap);
    chk("R4 x+1", result_o, x + 1);
    beat(y, gap);
    chk("R4 1+x+y", result_o, 1 + x + y);
    cnt = 1;
    if (poke) start_i = 1'b1;
    while (done_o !== 1'b1 && cnt < 300) begin
      @(negedge clk);
      start_i = 1'b0;
      cnt++;
    end
    start_i = 1'b0;
    if (t == 0) chk("R7 zero multiplier latency", cnt, 2);
    else        chk("R6 latency", cnt, b + p + 2);
    chk("R5 result", result_o, expv);
    @(negedge clk);
    chk("R8 done one cycle", done_o, 0);
    chk("R8 busy falls", busy_o, 0);
    repeat (3) @(negedge clk);
    chk("R8 result holds", result_o, expv);
  endtask

  task automatic reset_mid_run();
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    beat(8'd7, 0);
    beat(8'd9, 0);
    beat(8'd20, 0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R10 result cleared", result_o, 0);
    chk("R10 idle", busy_o, 0);
    chk("R10 done low", done_o, 0);
    run_case(8'd4, 8'd6, 8'd11, 8'd13, 0, 1'b0); // R10 recovery
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 result", result_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 busy", busy_o, 0);
    run_case(8'd3, 8'd5, 8'd10, 8'd2, 0, 1'b0);
    run_case(8'd0, 8'd0, 8'd0, 8'd0, 0, 1'b0);      // R7
    run_case(8'd12, 8'd34, 8'd77, 8'd0, 0, 1'b0);   // R7
    run_case(8'd1, 8'd2, 8'd200, 8'd128, 0, 1'b0);  // R6 single high bit
    run_case(8'd9, 8'd8, 8'd45, 8'hAA, 2, 1'b0);    // R3 gaps
    run_case(8'd255, 8'd255, 8'd255, 8'd255, 0, 1'b0); // R5 wrap to 0
    run_case(8'd17, 8'd3, 8'd99, 8'd1, 1, 1'b0);    // R3 gaps
    run_case(8'd6, 8'd7, 8'd33, 8'd19, 0, 1'b1);    // R9 start while busy
    reset_mid_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule